// File: doc/BRIEF.md
# Packed saturating rounding multiply-subtract

This block is the arithmetic core of one packed vector operation. Every lane takes a signed accumulator element, scales it up by the element width, and subtracts twice the exact product of two signed source elements. It then rounds the difference, keeps the upper half and clamps it to the element's signed range. The result goes back into the accumulator lane. The block works on one 64-bit slice, or on two slices when the quad control is set. Elements are 16 or 32 bits wide. The second multiplicand is either the matching lane of the second source or one lane broadcast to every lane.

Operands and pre-decoded control fields enter on a valid/ready stream. Results leave on a second valid/ready stream, together with per-slice write enables and an illegal-configuration flag. Back-pressure works like this: when `out_valid` is high and `out_ready` is low, the whole pipe freezes. The output word, the write enables and the illegal flag stay stable, and `in_ready` is low. An input transfer happens on a clock edge where both `in_valid` and `in_ready` are high. An output transfer happens on an edge where both `out_valid` and `out_ready` are high.

A sticky saturation flag records that at least one lane was clamped. The flag is cleared only through its own synchronous clear. The block also decodes the register number of the second source, for use by the register-file side.

Top module: `sat_mulsub_hi`

## Requirements
- R1: The size code selects the element width E: 2'b01 gives 16 bits and 2'b10 gives 32 bits. Codes 2'b00 and 2'b11 return `out_illegal`=1, `out_we`=2'b00 and `out_data`=0, and they leave the saturation flag unchanged.
- R2: `out_we[0]` covers `out_data[63:0]` and `out_we[1]` covers `out_data[127:64]`. A legal operation with quad=0 gives 2'b01, which is 4 lanes at 16 bits or 2 at 32 bits. With quad=1 it gives 2'b11.
- R3: Lane k occupies bits [k*E +: E] of every data bus. The lane result is sat(round((acc << E) - 2*src1*src2) >> E). All operands are signed, and the product is carried at full precision with no saturation.
- R4: Rounding adds 2^(E-1) to the difference and then shifts it right arithmetically by E, so exact halves go toward positive infinity.
- R5: A rounded value above 2^(E-1)-1 or below -2^(E-1) is clamped to that bound. This includes acc, src1 and src2 all at the most negative value.
- R6: `sat_flag` becomes 1 when a legal result in which any active lane clamped moves into the output stage. It stays 1 through later operations that do not clamp.
- R7: `sat_clr` clears `sat_flag` on the next edge. When a clamping result moves into the output stage on that same edge, the flag ends at 1.
- R8: In broadcast mode at 16 bits, every lane uses the element of `src2_data[63:0]` at index {`src2_ext`, `src2_field[3]`}.
- R9: In broadcast mode at 32 bits, every lane uses the element of `src2_data[63:0]` at index `src2_ext`.
- R10: With quad=1, an odd destination or odd first-source register is illegal. In lane mode an odd `src2_field` is also illegal. In broadcast mode the second-source parity is not checked, and with quad=0 no parity is checked. An illegal operation behaves as in R1.
- R11: A result appears on `out_valid` two edges after its input transfer. While `out_valid` is high and `out_ready` is low, `out_data` and `out_we` hold and `in_ready` is low.
- R12: `src2_reg` is combinational from the inputs. It is {`src2_ext`, `src2_field`} in lane mode, {0, `src2_field`} in 32-bit broadcast and {00, `src2_field[2:0]`} in 16-bit broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation accepted this edge if valid |
| size | input | 2 | Element width code |
| quad | input | 1 | Process both 64-bit slices |
| bcast | input | 1 | Broadcast one second-source lane |
| dst_lsb | input | 1 | Bit 0 of destination register number |
| src1_lsb | input | 1 | Bit 0 of first-source register number |
| src2_field | input | 4 | Second-source register field |
| src2_ext | input | 1 | Second-source extension bit |
| acc_data | input | 128 | Accumulator elements |
| src1_data | input | 128 | First-source elements |
| src2_data | input | 128 | Second-source elements |
| src2_reg | output | 5 | Decoded second-source register number |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes result |
| out_data | output | 128 | Result elements |
| out_we | output | 2 | Per-slice write enables |
| out_illegal | output | 1 | Configuration was illegal |
| sat_clr | input | 1 | Synchronous clear of the saturation flag |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
Two of the block's functions can fall in the same cycle: clearing the saturation flag and setting it again. A clamping result can move into the output stage on the same edge where `sat_clr` is applied. The bench provokes this by raising `sat_clr` in exactly the cycle between the input transfer and the output load of a saturating operation. It then judges that the flag reads 1 afterwards. A second run does the same with a non-clamping operation and expects the flag to read 0, which shows that the clear itself was applied.

// File: rtl/smh_pkg.sv
package smh_pkg;
  typedef enum logic [1:0] {
    SZ_RSV_LO = 2'b00,
    SZ_HALF   = 2'b01,
    SZ_WORD   = 2'b10,
    SZ_RSV_HI = 2'b11
  } elem_size_e;

  localparam int HALF_BITS = 16;
  localparam int WORD_BITS = 32;
endpackage

// File: rtl/smh_decode.sv
module smh_decode
  import smh_pkg::*;
(
  input  logic [1:0] size,
  input  logic       quad,
  input  logic       bcast,
  input  logic       dst_lsb,
  input  logic       src1_lsb,
  input  logic [3:0] src2_field,
  input  logic       src2_ext,
  output logic       illegal,
  output logic       wide,
  output logic [1:0] idx_half,
  output logic [0:0] idx_word,
  output logic [4:0] src2_reg
);
  logic size_ok;
  logic align_bad;

  always_comb begin
    size_ok   = (size == SZ_HALF) || (size == SZ_WORD);
    wide      = (size == SZ_WORD);
    align_bad = quad && (dst_lsb || src1_lsb || (!bcast && src2_field[0]));
    illegal   = !size_ok || align_bad;
    idx_half  = {src2_ext, src2_field[3]};
    idx_word  = src2_ext;
    if (!bcast)
      src2_reg = {src2_ext, src2_field};
    else if (wide)
      src2_reg = {1'b0, src2_field};
    else
      src2_reg = {2'b00, src2_field[2:0]};
  end
endmodule

// File: rtl/smh_opsel.sv
module smh_opsel #(
  parameter int SLICE_W = 64,
  parameter int NSLICE  = 2,
  parameter int ESIZE   = 16,
  localparam int LPS    = SLICE_W / ESIZE,
  localparam int NL     = LPS * NSLICE,
  localparam int IW     = (LPS > 1) ? $clog2(LPS) : 1,
  localparam int DW     = SLICE_W * NSLICE
) (
  input  logic          bcast,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] src2,
  output logic [DW-1:0] opnd
);
  logic [ESIZE-1:0] bcast_elem;
  assign bcast_elem = src2[idx*ESIZE +: ESIZE];

  for (genvar i = 0; i < NL; i++) begin : g_lane
    assign opnd[i*ESIZE +: ESIZE] = bcast ? bcast_elem : src2[i*ESIZE +: ESIZE];
  end
endmodule

// File: rtl/smh_lane.sv
module smh_lane #(
  parameter int E = 16,
  localparam int XW = 2 * E + 2
) (
  input  logic [E-1:0]          acc,
  input  logic [E-1:0]          a,
  input  logic [E-1:0]          b,
  output logic signed [XW-1:0]  diff
);
  logic signed [2*E-1:0] a_x, b_x, prod;
  logic signed [XW-1:0]  acc_x, dbl;

  always_comb begin
    a_x   = {{E{a[E-1]}}, a};
    b_x   = {{E{b[E-1]}}, b};
    prod  = a_x * b_x;
    acc_x = {{2{acc[E-1]}}, acc, {E{1'b0}}};
    dbl   = {prod[2*E-1], prod, 1'b0};
    diff  = acc_x - dbl;
  end
endmodule

// File: rtl/smh_rndsat.sv
module smh_rndsat #(
  parameter int E = 16,
  localparam int XW = 2 * E + 2
) (
  input  logic signed [XW-1:0] diff,
  output logic [E-1:0]         res,
  output logic                 sat
);
  localparam logic signed [XW-1:0] HALF = {{(XW-E){1'b0}}, 1'b1, {(E-1){1'b0}}};
  localparam logic signed [XW-1:0] MAXV = {{(XW-E+1){1'b0}}, {(E-1){1'b1}}};
  localparam logic signed [XW-1:0] MINV = {{(XW-E+1){1'b1}}, {(E-1){1'b0}}};

  logic signed [XW-1:0] sum_sh;
  logic sat_hi, sat_lo;

  always_comb begin
    sum_sh = (diff + HALF) >>> E;
    sat_hi = sum_sh > MAXV;
    sat_lo = sum_sh < MINV;
    sat    = sat_hi || sat_lo;
    if (sat_hi)      res = MAXV[E-1:0];
    else if (sat_lo) res = MINV[E-1:0];
    else             res = sum_sh[E-1:0];
  end
endmodule

// File: rtl/sat_mulsub_hi.sv
module sat_mulsub_hi
  import smh_pkg::*;
#(
  parameter int SLICE_W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [1:0]   size,
  input  logic         quad,
  input  logic         bcast,
  input  logic         dst_lsb,
  input  logic         src1_lsb,
  input  logic [3:0]   src2_field,
  input  logic         src2_ext,
  input  logic [2*SLICE_W-1:0] acc_data,
  input  logic [2*SLICE_W-1:0] src1_data,
  input  logic [2*SLICE_W-1:0] src2_data,
  output logic [4:0]   src2_reg,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [2*SLICE_W-1:0] out_data,
  output logic [1:0]   out_we,
  output logic         out_illegal,
  input  logic         sat_clr,
  output logic         sat_flag
);
  localparam int NSLICE = 2;
  localparam int DW     = SLICE_W * NSLICE;
  localparam int EH     = HALF_BITS;
  localparam int EW     = WORD_BITS;
  localparam int LPS_H  = SLICE_W / EH;
  localparam int LPS_W  = SLICE_W / EW;
  localparam int LH     = LPS_H * NSLICE;
  localparam int LW     = LPS_W * NSLICE;
  localparam int IWH    = $clog2(LPS_H);
  localparam int IWW    = (LPS_W > 1) ? $clog2(LPS_W) : 1;
  localparam int XH     = 2 * EH + 2;
  localparam int XW     = 2 * EW + 2;

  // ---------------- decode ----------------
  logic       dec_illegal, dec_wide;
  logic [1:0] idx_half;
  logic [0:0] idx_word;

  smh_decode u_dec (
    .size       (size),
    .quad       (quad),
    .bcast      (bcast),
    .dst_lsb    (dst_lsb),
    .src1_lsb   (src1_lsb),
    .src2_field (src2_field),
    .src2_ext   (src2_ext),
    .illegal    (dec_illegal),
    .wide       (dec_wide),
    .idx_half   (idx_half),
    .idx_word   (idx_word),
    .src2_reg   (src2_reg)
  );

  // ---------------- flow control ----------------
  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  // ---------------- operand select ----------------
  logic [DW-1:0] opnd_h, opnd_w;

  smh_opsel #(.SLICE_W(SLICE_W), .NSLICE(NSLICE), .ESIZE(EH)) u_sel_h (
    .bcast (bcast),
    .idx   (idx_half[IWH-1:0]),
    .src2  (src2_data),
    .opnd  (opnd_h)
  );

  smh_opsel #(.SLICE_W(SLICE_W), .NSLICE(NSLICE), .ESIZE(EW)) u_sel_w (
    .bcast (bcast),
    .idx   (idx_word[IWW-1:0]),
    .src2  (src2_data),
    .opnd  (opnd_w)
  );

  // ---------------- stage 1 control ----------------
  logic s1_valid, s1_wide, s1_ill, s1_quad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_wide  <= 1'b0;
      s1_ill   <= 1'b0;
      s1_quad  <= 1'b0;
    end else if (adv) begin
      s1_valid <= in_valid;
      s1_wide  <= dec_wide;
      s1_ill   <= dec_illegal;
      s1_quad  <= quad;
    end
  end

  // ---------------- lane arrays ----------------
  logic [DW-1:0] res_h, res_w;
  logic [LH-1:0] sat_h, act_h;
  logic [LW-1:0] sat_w, act_w;

  for (genvar i = 0; i < LH; i++) begin : g_half
    logic signed [XH-1:0] d_c, d_q;

    smh_lane #(.E(EH)) u_lane (
      .acc  (acc_data[i*EH +: EH]),
      .a    (src1_data[i*EH +: EH]),
      .b    (opnd_h[i*EH +: EH]),
      .diff (d_c)
    );

    always_ff @(posedge clk) begin
      if (adv) d_q <= d_c;
    end

    smh_rndsat #(.E(EH)) u_rs (
      .diff (d_q),
      .res  (res_h[i*EH +: EH]),
      .sat  (sat_h[i])
    );

    if (i < LPS_H) begin : g_lo
      assign act_h[i] = 1'b1;
    end else begin : g_hi
      assign act_h[i] = s1_quad;
    end
  end

  for (genvar i = 0; i < LW; i++) begin : g_word
    logic signed [XW-1:0] d_c, d_q;

    smh_lane #(.E(EW)) u_lane (
      .acc  (acc_data[i*EW +: EW]),
      .a    (src1_data[i*EW +: EW]),
      .b    (opnd_w[i*EW +: EW]),
      .diff (d_c)
    );

    always_ff @(posedge clk) begin
      if (adv) d_q <= d_c;
    end

    smh_rndsat #(.E(EW)) u_rs (
      .diff (d_q),
      .res  (res_w[i*EW +: EW]),
      .sat  (sat_w[i])
    );

    if (i < LPS_W) begin : g_lo
      assign act_w[i] = 1'b1;
    end else begin : g_hi
      assign act_w[i] = s1_quad;
    end
  end

  // ---------------- stage 2 / output ----------------
  logic any_sat, sat_set;
  assign any_sat = s1_wide ? |(sat_w & act_w) : |(sat_h & act_h);
  assign sat_set = adv && s1_valid && !s1_ill && any_sat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_we      <= 2'b00;
      out_illegal <= 1'b0;
    end else if (adv) begin
      out_valid   <= s1_valid;
      out_illegal <= s1_ill;
      out_data    <= s1_ill ? '0 : (s1_wide ? res_w : res_h);
      out_we      <= s1_ill ? 2'b00 : (s1_quad ? 2'b11 : 2'b01);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sat_flag <= 1'b0;
    else if (sat_set) sat_flag <= 1'b1;
    else if (sat_clr) sat_flag <= 1'b0;
  end
endmodule

// File: rtl/smh_checker.sv
module smh_checker (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [127:0] out_data,
  input logic [1:0]   out_we,
  input logic         out_illegal,
  input logic         sat_clr,
  input logic         sat_set,
  input logic         sat_flag
);
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> out_we == 2'b00); // R1

  AST_WE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_illegal |-> (out_we == 2'b01 || out_we == 2'b11)); // R2

  AST_SAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sat_flag && !sat_clr |=> sat_flag); // R6

  AST_SAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    sat_clr && !sat_set |=> !sat_flag); // R7

  AST_SAT_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    sat_set |=> sat_flag); // R7

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |-> ##2 out_valid); // R11

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_we)); // R11

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R11
endmodule

bind sat_mulsub_hi smh_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .out_we      (out_we),
  .out_illegal (out_illegal),
  .sat_clr     (sat_clr),
  .sat_set     (sat_set),
  .sat_flag    (sat_flag)
);

// File: tb/tb_sat_mulsub_hi.sv
`timescale 1ns/1ps
module tb_sat_mulsub_hi;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic         in_valid = 1'b0, in_ready;
  logic [1:0]   size = 2'b01;
  logic         quad = 1'b0, bcast = 1'b0, dst_lsb = 1'b0, src1_lsb = 1'b0;
  logic [3:0]   src2_field = 4'd0;
  logic         src2_ext = 1'b0;
  logic [127:0] acc_data = '0, src1_data = '0, src2_data = '0;
  logic [4:0]   src2_reg;
  logic         out_valid, out_ready = 1'b1, out_illegal, sat_flag;
  logic         sat_clr = 1'b0;
  logic [127:0] out_data;
  logic [1:0]   out_we;

  sat_mulsub_hi dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .size(size), .quad(quad), .bcast(bcast), .dst_lsb(dst_lsb), .src1_lsb(src1_lsb),
    .src2_field(src2_field), .src2_ext(src2_ext), .acc_data(acc_data),
    .src1_data(src1_data), .src2_data(src2_data), .src2_reg(src2_reg),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_we(out_we), .out_illegal(out_illegal), .sat_clr(sat_clr), .sat_flag(sat_flag)
  );

  int n_chk = 0, n_fail = 0;
  logic [127:0] g_data;
  logic [1:0]   g_we;
  logic         g_ill;
  logic [4:0]   g_reg;
  logic         exp_flag = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic signed [71:0] sext(input logic [127:0] v, input int k, input int e);
    logic [127:0] t;
    t = v >> (k * e);
    if (e == 16) return {{56{t[15]}}, t[15:0]};
    return {{40{t[31]}}, t[31:0]};
  endfunction

  // Independent model built from R3, R4, R5, R8, R9
  function automatic void ref_op(input logic [1:0] sz, input logic bc, input logic [3:0] f,
                                 input logic e, input logic [127:0] ac, aa, bb,
                                 output logic [127:0] res, output logic [15:0] satv);
    int ew, n, idx;
    ew  = (sz == 2'b10) ? 32 : 16;
    n   = 128 / ew;
    idx = (ew == 16) ? int'({e, f[3]}) : int'(e);
    res = '0;
    satv = '0;
    for (int k = 0; k < n; k++) begin
      logic signed [71:0] x, y, z, p, r, mx;
      x  = sext(ac, k, ew);
      y  = sext(aa, k, ew);
      z  = bc ? sext(bb, idx, ew) : sext(bb, k, ew);
      p  = (x <<< ew) - 72'sd2 * y * z;
      r  = (p + (72'sd1 <<< (ew - 1))) >>> ew;
      mx = (72'sd1 <<< (ew - 1)) - 72'sd1;
      if (r > mx) begin r = mx; satv[k] = 1'b1; end
      else if (r < -mx - 72'sd1) begin r = -mx - 72'sd1; satv[k] = 1'b1; end
      if (ew == 16) res |= {112'b0, r[15:0]} << (k * ew);
      else          res |= {96'b0, r[31:0]} << (k * ew);
    end
  endfunction

  task automatic do_op(input logic [1:0] sz, input logic q, bc, dl, sl, input logic [3:0] f,
                       input logic e, input logic [127:0] ac, aa, bb, input logic clr_mid);
    @(negedge clk);
    size = sz; quad = q; bcast = bc; dst_lsb = dl; src1_lsb = sl;
    src2_field = f; src2_ext = e; acc_data = ac; src1_data = aa; src2_data = bb;
    in_valid = 1'b1;
    #0.5 g_reg = src2_reg;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    sat_clr = clr_mid;
    check(out_valid == 1'b0, "R11 no result one edge after transfer", 128'(out_valid), 128'd0);
    @(posedge clk);
    @(negedge clk);
    sat_clr = 1'b0;
    check(out_valid == 1'b1, "R11 result two edges after transfer", 128'(out_valid), 128'd1);
    g_data = out_data; g_we = out_we; g_ill = out_illegal;
  endtask

  task automatic run_legal(input string tag, input logic [1:0] sz, input logic q, bc,
                           input logic [3:0] f, input logic e, input logic [127:0] ac, aa, bb,
                           input logic clr_mid);
    logic [127:0] exp_d, mask;
    logic [15:0]  sv;
    logic         any;
    ref_op(sz, bc, f, e, ac, aa, bb, exp_d, sv);
    any = q ? |sv : ((sz == 2'b10) ? |sv[1:0] : |sv[3:0]);
    mask = q ? {128{1'b1}} : {64'b0, {64{1'b1}}};
    do_op(sz, q, bc, 1'b0, 1'b0, f, e, ac, aa, bb, clr_mid);
    exp_flag = any ? 1'b1 : (clr_mid ? 1'b0 : exp_flag);
    check((g_data & mask) == (exp_d & mask), {tag, " R3 data"}, g_data & mask, exp_d & mask);
    check(g_we == (q ? 2'b11 : 2'b01), {tag, " R2 write enables"}, 128'(g_we), 128'(q ? 2'b11 : 2'b01));
    check(g_ill == 1'b0, {tag, " R10 legal"}, 128'(g_ill), 128'd0);
    check(sat_flag == exp_flag, {tag, " R6 flag"}, 128'(sat_flag), 128'(exp_flag));
  endtask

  task automatic clear_flag();
    @(negedge clk); sat_clr = 1'b1;
    @(negedge clk); sat_clr = 1'b0;
    exp_flag = 1'b0;
    check(sat_flag == 1'b0, "R7 clear alone", 128'(sat_flag), 128'd0);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic t_reset();
    check(out_valid == 1'b0, "R11 reset out_valid", 128'(out_valid), 128'd0);
    check(in_ready == 1'b1, "R11 reset in_ready", 128'(in_ready), 128'd1);
    check(sat_flag == 1'b0, "R6 reset flag", 128'(sat_flag), 128'd0);
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 16; i++) begin
      logic [1:0] sz;
      sz = (i % 2 == 0) ? 2'b01 : 2'b10;
      run_legal("R3 sweep", sz, i[1], 1'b0, 4'd2, 1'b0, rnd128(), rnd128(), rnd128(), 1'b0);
    end
  endtask

  task automatic t_round();
    logic [127:0] ac, aa, bb;
    clear_flag();
    ac = {64'b0, 16'd1, 16'd0, 16'd0, 16'd0};
    aa = {64'b0, 16'd0, 16'd64, 16'hff80, 16'd128};
    bb = {64'b0, 16'd0, 16'd128, 16'd128, 16'd128};
    run_legal("R4 ties", 2'b01, 1'b0, 1'b0, 4'd0, 1'b0, ac, aa, bb, 1'b0);
    check(g_data[63:0] == 64'h0001_0000_0001_0000, "R4 half goes up", g_data[63:0], 128'h0001_0000_0001_0000);
  endtask

  task automatic t_sat();
    logic [127:0] mn16, mx16, mn32;
    mn16 = {8{16'h8000}};
    mx16 = {8{16'h7fff}};
    mn32 = {4{32'h8000_0000}};
    clear_flag();
    run_legal("R5 min 16", 2'b01, 1'b1, 1'b0, 4'd0, 1'b0, mn16, mn16, mn16, 1'b0);
    check(g_data == mn16, "R5 clamp low 16", g_data, mn16);
    check(sat_flag == 1'b1, "R6 flag set", 128'(sat_flag), 128'd1);
    run_legal("R5 max 16", 2'b01, 1'b0, 1'b0, 4'd0, 1'b0, mx16, mx16, mn16, 1'b0);
    check(g_data[63:0] == mx16[63:0], "R5 clamp high 16", g_data[63:0], mx16[63:0]);
    run_legal("R5 min 32", 2'b10, 1'b1, 1'b0, 4'd0, 1'b0, mn32, mn32, mn32, 1'b0);
    check(g_data == mn32, "R5 clamp low 32", g_data, mn32);
    run_legal("R6 sticky", 2'b01, 1'b0, 1'b0, 4'd0, 1'b0, '0, '0, '0, 1'b0);
    check(sat_flag == 1'b1, "R6 kept after clean op", 128'(sat_flag), 128'd1);
  endtask

  task automatic t_clear();
    logic [127:0] mn16;
    mn16 = {8{16'h8000}};
    clear_flag();
    run_legal("R7 set vs clear", 2'b01, 1'b0, 1'b0, 4'd0, 1'b0, mn16, mn16, mn16, 1'b1);
    check(sat_flag == 1'b1, "R7 set wins over clear", 128'(sat_flag), 128'd1);
    run_legal("R7 clear during clean op", 2'b01, 1'b0, 1'b0, 4'd0, 1'b0, '0, '0, '0, 1'b1);
    check(sat_flag == 1'b0, "R7 clear applied", 128'(sat_flag), 128'd0);
  endtask

  task automatic t_bcast();
    for (int i = 0; i < 4; i++) begin
      logic [1:0] ix;
      ix = i[1:0];
      run_legal("R8 bcast16", 2'b01, 1'b1, 1'b1, {ix[0], 3'd5}, ix[1], rnd128(), rnd128(), rnd128(), 1'b0);
      check(g_reg == 5'd5, "R12 bcast16 reg", 128'(g_reg), 128'd5);
    end
    for (int i = 0; i < 2; i++) begin
      run_legal("R9 bcast32", 2'b10, 1'b1, 1'b1, 4'b1011, i[0], rnd128(), rnd128(), rnd128(), 1'b0);
      check(g_reg == 5'd11, "R12 bcast32 reg", 128'(g_reg), 128'd11);
    end
    run_legal("R12 lane mode", 2'b10, 1'b1, 1'b0, 4'b0110, 1'b1, rnd128(), rnd128(), rnd128(), 1'b0);
    check(g_reg == 5'd22, "R12 lane-mode reg", 128'(g_reg), 128'd22);
  endtask

  task automatic run_illegal(input string tag, input logic [1:0] sz, input logic q, bc, dl, sl,
                             input logic [3:0] f);
    logic [127:0] mn;
    mn = {8{16'h8000}};
    do_op(sz, q, bc, dl, sl, f, 1'b0, mn, mn, mn, 1'b0);
    check(g_ill == 1'b1, {tag, " flagged"}, 128'(g_ill), 128'd1);
    check(g_we == 2'b00, {tag, " no write"}, 128'(g_we), 128'd0);
    check(g_data == '0, {tag, " zero data"}, g_data, 128'd0);
    check(sat_flag == 1'b0, {tag, " flag untouched"}, 128'(sat_flag), 128'd0);
  endtask

  task automatic t_illegal();
    clear_flag();
    run_illegal("R1 size 00", 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0);
    run_illegal("R1 size 11", 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0);
    run_illegal("R10 odd dst", 2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 4'd0);
    run_illegal("R10 odd src1", 2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 4'd0);
    run_illegal("R10 odd src2", 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3);
    do_op(2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 4'd3, 1'b0, '0, '0, '0, 1'b0);
    check(g_ill == 1'b0, "R10 single slice ignores parity", 128'(g_ill), 128'd0);
  endtask

  task automatic t_stall();
    logic [127:0] aa, bb, e1, e2;
    logic [15:0]  sv;
    aa = rnd128(); bb = rnd128();
    ref_op(2'b01, 1'b0, 4'd0, 1'b0, '0, aa, bb, e1, sv);
    ref_op(2'b10, 1'b0, 4'd0, 1'b0, '0, bb, aa, e2, sv);
    @(negedge clk);
    out_ready = 1'b0;
    size = 2'b01; quad = 1'b1; bcast = 1'b0; dst_lsb = 1'b0; src1_lsb = 1'b0;
    src2_field = 4'd0; src2_ext = 1'b0; acc_data = '0; src1_data = aa; src2_data = bb;
    in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    check(out_valid == 1'b1, "R11 stalled result present", 128'(out_valid), 128'd1);
    check(in_ready == 1'b0, "R11 in_ready low under stall", 128'(in_ready), 128'd0);
    size = 2'b10; src1_data = bb; src2_data = aa; in_valid = 1'b1;
    repeat (3) @(negedge clk);
    check(out_data == e1, "R11 data held under stall", out_data, e1);
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b0, "R11 drained", 128'(out_valid), 128'd0);
    @(posedge clk); @(negedge clk);
    check(out_valid == 1'b1 && out_data == e2, "R11 queued op after stall", out_data, e2);
    exp_flag = sat_flag;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog R11 actual=timeout expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_sweep();
    t_round();
    t_sat();
    t_clear();
    t_bcast();
    t_illegal();
    t_stall();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule